// File: doc/BRIEF.md
# Misaligned Word-Bus Load Unit

This unit sits between a processor load port and a memory read bus that is organised in 32-bit words and never sees the two lowest byte-address bits. A load of 1, 2 or 4 bytes arrives with a byte address. The unit turns it into one or two word reads on the bus. It picks the wanted bytes out of the returned word or words and widens the result to 32 bits, with either sign or zero extension.

Loads whose address is a multiple of their size need exactly one word read. A load whose bytes run past the end of a word needs a second read at the following word. A mode pin chooses how misaligned loads are handled. In merge mode, the unit issues one or two reads and joins the pieces. In strict mode, any misaligned load is refused with a fault and no bus traffic.

Both the request side and the bus address side use valid/ready handshakes. A request is taken only while the unit is idle, so only one load is ever in flight. The response holds `rsp_valid`, `rsp_data` and `rsp_fault` steady until `rsp_ready` accepts them. The bus address stays asserted and unchanged until `bus_req_ready` is seen. Returned bus data is always accepted and comes back on a single-cycle `bus_rsp_valid`.

Top module: `ldw_load_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, `req_ready` is 1, `rsp_valid` is 0 and `bus_req_valid` is 0.
- R2: The size code selects the load width: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. An aligned load (byte address modulo size equal to zero) makes exactly one bus read, at word address `req_addr[ADDR_W-1:2]`.
- R3: Byte order is little-endian. The byte at the request address goes to `rsp_data[7:0]`, the next address to `[15:8]`, and so on for the load width.
- R4: For 1- and 2-byte loads, `req_signed`=1 fills the upper bits with the top bit of the loaded value, and `req_signed`=0 fills them with zeros. A 4-byte result is returned unchanged.
- R5: With `cfg_split`=1, a load whose byte offset plus width exceeds 4 makes two reads. The first is at word W and the second at W+1, which wraps to 0 past the highest word. The bytes of both reads are joined in address order.
- R6: With `cfg_split`=1, a misaligned load that stays within one word (a 2-byte load at offset 1) makes only one bus read.
- R7: With `cfg_split`=0, a misaligned load makes no bus read and returns `rsp_fault`=1 with `rsp_data`=0. Aligned loads return `rsp_fault`=0 in either mode.
- R8: `rsp_valid` rises in the cycle right after the cycle in which the last bus word is accepted. It then stays high, with data and fault held, until `rsp_ready` is 1.
- R9: `req_ready` is 1 only while no load is in progress. `bus_req_valid` stays high with a constant `bus_req_addr` until `bus_req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_split | input | 1 | 1 = join misaligned loads from one or two reads, 0 = fault on misaligned loads |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | 2 | Width code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_signed | input | 1 | 1 = sign-extend, 0 = zero-extend narrow results |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 32 | Extended load result, 0 on fault |
| rsp_fault | output | 1 | Alignment fault for this load |
| bus_req_valid | output | 1 | Word read address present |
| bus_req_ready | input | 1 | Bus accepts the address |
| bus_req_addr | output | ADDR_W-2 | Word address |
| bus_rsp_valid | input | 1 | Read word returned, one cycle |
| bus_rsp_data | input | 32 | Returned word |

## Verification
The bench sweeps every byte offset, every size code, both extension settings and both modes. It does this at several base addresses, one of them the last word of the address space, while varying bus stall and latency and response back-pressure.

The bench goes after several specific faults:
- A lane shift off by one byte, or a big-endian join, would corrupt the data of straddling loads.
- A missing wrap, or a wrong increment of the second word address, would show up as a bad second bus address.
- Misclassifying the 2-byte load at offset 1 would show up in the bus read count. It would either issue a needless second read or fault when merge mode should serve it.
- A strict-mode fault that still reaches the bus would be seen as a nonzero read count.
- Extending from the wrong bit would produce wrong upper bytes, using test data that has both high and low top bits.

// File: rtl/ldw_pkg.sv
package ldw_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int OFF_W      = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } ld_size_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR0 = 3'd1,
    ST_DATA0 = 3'd2,
    ST_ADDR1 = 3'd3,
    ST_DATA1 = 3'd4,
    ST_RESP  = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic [OFF_W:0] nbytes;
    logic           misaligned;
    logic           straddle;
  } ld_shape_t;
endpackage

// File: rtl/ldw_shape_decode.sv
module ldw_shape_decode
  import ldw_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       size,
  output ld_shape_t        shape
);
  logic [OFF_W:0] nb;
  logic [OFF_W:0] mask;
  logic [OFF_W:0] end_pos;

  always_comb begin
    case (ld_size_e'(size))
      SZ_BYTE: nb = (OFF_W+1)'(1);
      SZ_HALF: nb = (OFF_W+1)'(2);
      default: nb = (OFF_W+1)'(WORD_BYTES);
    endcase
  end

  // low-bit mask of the width: nonzero overlap with the offset means misaligned
  assign mask    = nb - (OFF_W+1)'(1);
  assign end_pos = {1'b0, off} + nb;

  assign shape.nbytes     = nb;
  assign shape.misaligned = |({1'b0, off} & mask);
  assign shape.straddle   = end_pos > (OFF_W+1)'(WORD_BYTES);
endmodule

// File: rtl/ldw_lane_merge.sv
module ldw_lane_merge
  import ldw_pkg::*;
(
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] hi_word,
  input  logic [OFF_W-1:0]  off,
  input  logic [OFF_W:0]    nbytes,
  input  logic              sgn,
  input  logic              fault,
  output logic [WORD_W-1:0] data
);
  logic [2*WORD_W-1:0] pair_w;
  logic [WORD_W-1:0]   window_w;
  logic                sign_bit;
  logic                unused_hi_top;

  // lower word holds the lower addresses; a byte offset slides the window up
  assign pair_w        = {hi_word, lo_word};
  assign window_w      = pair_w[{off, 3'b000} +: WORD_W];
  assign unused_hi_top = ^hi_word[WORD_W-1 -: 8];

  always_comb begin
    sign_bit = 1'b0;
    for (int i = 1; i <= WORD_BYTES; i++) begin
      if (nbytes == (OFF_W+1)'(i)) sign_bit = window_w[8*i-1];
    end
  end

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    logic keep;
    assign keep = (OFF_W+1)'(g) < nbytes;
    assign data[8*g +: 8] = fault ? 8'h00 :
                            keep  ? window_w[8*g +: 8] :
                                    {8{sgn & sign_bit}};
  end
endmodule

// File: rtl/ldw_seq_ctrl.sv
module ldw_seq_ctrl
  import ldw_pkg::*;
#(
  parameter int WADDR_W = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               split_mode,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [WADDR_W-1:0] req_word,
  input  logic               req_misaligned,
  input  logic               req_straddle,
  output logic               bus_req_valid,
  input  logic               bus_req_ready,
  output logic [WADDR_W-1:0] bus_req_addr,
  input  logic               bus_rsp_valid,
  output logic               cap_lo,
  output logic               cap_hi,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_fault
);
  seq_state_e         st;
  logic [WADDR_W-1:0] word_q;
  logic               two_q;
  logic               fault_q;
  logic               refuse;

  assign refuse = req_misaligned && !split_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      word_q  <= '0;
      two_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          word_q  <= req_word;
          two_q   <= req_straddle;
          fault_q <= refuse;
          st      <= refuse ? ST_RESP : ST_ADDR0;
        end
        ST_ADDR0: if (bus_req_ready) st <= ST_DATA0;
        ST_DATA0: if (bus_rsp_valid) st <= two_q ? ST_ADDR1 : ST_RESP;
        ST_ADDR1: if (bus_req_ready) st <= ST_DATA1;
        ST_DATA1: if (bus_rsp_valid) st <= ST_RESP;
        ST_RESP:  if (rsp_ready)     st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == ST_IDLE);
  assign bus_req_valid = (st == ST_ADDR0) || (st == ST_ADDR1);
  // word counter wraps naturally at the top of the address space
  assign bus_req_addr  = (st == ST_ADDR1) ? word_q + WADDR_W'(1) : word_q;
  assign cap_lo        = (st == ST_DATA0) && bus_rsp_valid;
  assign cap_hi        = (st == ST_DATA1) && bus_rsp_valid;
  assign rsp_valid     = (st == ST_RESP);
  assign rsp_fault     = fault_q;

  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr));

  // R7
  strict_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_misaligned && !split_mode |=> rsp_valid && rsp_fault && !bus_req_valid);

  // R8
  resp_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_hi || (cap_lo && !two_q)) |=> rsp_valid && !rsp_fault);

  // R9
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> !req_ready);
endmodule

// File: rtl/ldw_load_unit.sv
module ldw_load_unit
  import ldw_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_split,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data,
  output logic              rsp_fault,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [ADDR_W-3:0] bus_req_addr,
  input  logic              bus_rsp_valid,
  input  logic [31:0]       bus_rsp_data
);
  localparam int WADDR_W = ADDR_W - OFF_W;

  ld_shape_t         shape;
  logic              accept;
  logic              cap_lo, cap_hi;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W:0]    nb_q;
  logic              sgn_q;
  logic [WORD_W-1:0] lo_q, hi_q;

  ldw_shape_decode u_decode (
    .off   (req_addr[OFF_W-1:0]),
    .size  (req_size),
    .shape (shape)
  );

  ldw_seq_ctrl #(.WADDR_W(WADDR_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .split_mode     (cfg_split),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_word       (req_addr[ADDR_W-1:OFF_W]),
    .req_misaligned (shape.misaligned),
    .req_straddle   (shape.straddle),
    .bus_req_valid  (bus_req_valid),
    .bus_req_ready  (bus_req_ready),
    .bus_req_addr   (bus_req_addr),
    .bus_rsp_valid  (bus_rsp_valid),
    .cap_lo         (cap_lo),
    .cap_hi         (cap_hi),
    .rsp_valid      (rsp_valid),
    .rsp_ready      (rsp_ready),
    .rsp_fault      (rsp_fault)
  );

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q <= '0;
      nb_q  <= '0;
      sgn_q <= 1'b0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      if (accept) begin
        off_q <= req_addr[OFF_W-1:0];
        nb_q  <= shape.nbytes;
        sgn_q <= req_signed;
      end
      if (cap_lo) lo_q <= bus_rsp_data;
      if (cap_hi) hi_q <= bus_rsp_data;
    end
  end

  ldw_lane_merge u_merge (
    .lo_word (lo_q),
    .hi_word (hi_q),
    .off     (off_q),
    .nbytes  (nb_q),
    .sgn     (sgn_q),
    .fault   (rsp_fault),
    .data    (rsp_data)
  );

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_fault));

  // R4
  zext_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault && !sgn_q && nb_q == (OFF_W+1)'(1) |-> rsp_data[31:8] == 24'h0);

  // R7
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_data == 32'h0);
endmodule

// File: tb/ldw_load_unit_tb.sv
module ldw_load_unit_tb;
  localparam int AW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, cfg_split, req_valid, req_ready, req_signed;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic          rsp_valid, rsp_ready, rsp_fault;
  logic [31:0]   rsp_data;
  logic          bus_req_valid, bus_req_ready, bus_rsp_valid;
  logic [AW-3:0] bus_req_addr;
  logic [31:0]   bus_rsp_data;

  ldw_load_unit #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_signed(req_signed),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_fault(rsp_fault),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready), .bus_req_addr(bus_req_addr),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_data(bus_rsp_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bus model controls and observations
  int            lat_sel = 0;
  int            stall_sel = 0;
  int            stall_left = 0;
  int            rd_count = 0;
  logic [AW-3:0] rd_addr [2];
  int            rsp_cyc = 0;
  logic          pend = 1'b0;
  logic [AW-3:0] pend_addr;
  int            pend_dly = 0;

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    logic [15:0] t;
    t = a * 16'd29 + (a >> 5) + 16'd7;
    return t[7:0] ^ {a[3:0], a[11:8]};
  endfunction

  function automatic logic [31:0] mem_word(input logic [AW-3:0] w);
    return {mem_byte({w, 2'd3}), mem_byte({w, 2'd2}), mem_byte({w, 2'd1}), mem_byte({w, 2'd0})};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    bus_req_ready = 1'b0;
    bus_rsp_valid = 1'b0;
    bus_rsp_data  = 32'h0;
    forever begin
      @(negedge clk);
      bus_rsp_valid = 1'b0;
      if (pend) begin
        if (pend_dly == 0) begin
          bus_rsp_valid = 1'b1;
          bus_rsp_data  = mem_word(pend_addr);
          pend          = 1'b0;
          rsp_cyc       = cyc;
        end else begin
          pend_dly--;
        end
      end
      bus_req_ready = 1'b0;
      if (bus_req_valid && !pend && !bus_rsp_valid) begin
        if (stall_left > 0) stall_left--;
        else begin
          bus_req_ready = 1'b1;
          if (rd_count < 2) rd_addr[rd_count] = bus_req_addr;
          rd_count++;
          pend       = 1'b1;
          pend_addr  = bus_req_addr;
          pend_dly   = lat_sel;
          stall_left = stall_sel;
        end
      end
    end
  end

  task automatic run_load(input logic [AW-1:0] a, input logic [1:0] sz, input logic sg,
                          input logic split, input bit bp);
    int            nb;
    bit            mis, strad, exp_fault;
    int            exp_reads, t;
    logic [31:0]   exp, held;
    logic [AW-3:0] w0;
    string         dtag;
    nb        = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    mis       = (int'(a[1:0]) % nb) != 0;
    strad     = (int'(a[1:0]) + nb) > 4;
    exp_fault = mis && !split;
    exp_reads = exp_fault ? 0 : (strad ? 2 : 1);
    w0        = a[AW-1:2];
    exp       = 32'h0;
    if (!exp_fault) begin
      for (int i = 0; i < nb; i++) exp[8*i +: 8] = mem_byte(a + AW'(i));
      if (sg && nb < 4 && exp[8*nb-1])
        for (int i = nb; i < 4; i++) exp[8*i +: 8] = 8'hFF;
    end
    dtag = strad ? "R5 joined data" : (sg ? "R4 extended data" : "R3 lane data");

    rd_count   = 0;
    stall_left = stall_sel;
    @(negedge clk);
    cfg_split  = split;
    req_addr   = a;
    req_size   = sz;
    req_signed = sg;
    req_valid  = 1'b1;
    rsp_ready  = !bp;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R9 busy after accept", 32'(req_ready), 32'h0);
    t = 0;
    while (!rsp_valid && t < 200) begin
      @(negedge clk);
      t++;
    end
    check(rsp_valid, "R8 response arrives", 32'(rsp_valid), 32'h1);
    check(rsp_fault == exp_fault, "R7 fault flag", 32'(rsp_fault), 32'(exp_fault));
    check(rsp_data == exp, exp_fault ? "R7 fault data" : dtag, rsp_data, exp);
    check(rd_count == exp_reads, strad ? "R5 read count" : (mis ? "R6/R7 read count" : "R2 read count"),
          32'(rd_count), 32'(exp_reads));
    if (exp_reads >= 1)
      check(rd_addr[0] == w0, "R2 first word address", 32'(rd_addr[0]), 32'(w0));
    if (exp_reads == 2)
      check(rd_addr[1] == w0 + 1'b1, "R5 second word address", 32'(rd_addr[1]), 32'(AW'(w0 + 1'b1)));
    if (!exp_fault)
      check(cyc == rsp_cyc + 1, "R8 response timing", 32'(cyc), 32'(rsp_cyc + 1));
    if (bp) begin
      held = rsp_data;
      repeat (2) begin
        @(negedge clk);
        check(rsp_valid && rsp_data == held, "R8 hold under back-pressure", rsp_data, held);
      end
      rsp_ready = 1'b1;
    end
    @(negedge clk);
    check(!rsp_valid && req_ready, "R9 idle after take", {30'h0, rsp_valid, req_ready}, 32'h1);
  endtask

  bit done = 1'b0;

  initial begin
    logic [AW-1:0] bases [4];
    int            idx;
    bases[0] = 16'h0010;
    bases[1] = 16'h1230;
    bases[2] = 16'hFFFC;
    bases[3] = 16'h8040;
    rst_n = 1'b0; cfg_split = 1'b1; req_valid = 1'b0; req_addr = '0;
    req_size = 2'd0; req_signed = 1'b0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !bus_req_valid, "R1 in reset",
          {29'h0, req_ready, rsp_valid, bus_req_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !bus_req_valid, "R1 after reset",
          {29'h0, req_ready, rsp_valid, bus_req_valid}, 32'h4);
    idx = 0;
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 4; o++)
        for (int s = 0; s < 4; s++)
          for (int g = 0; g < 2; g++)
            for (int m = 0; m < 2; m++) begin
              lat_sel   = idx % 3;
              stall_sel = (idx / 3) % 2;
              run_load(bases[b] + AW'(o), 2'(s), 1'(g), 1'(m), (idx % 5) == 0);
              idx++;
            end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule